// File: doc/BRIEF.md
# Four-Port GPIO Register Bank

This block is a register-mapped general-purpose I/O bank with four ports of eight pins each, 32 pins in all. Each port holds three writable registers: an ownership register that hands the pin to GPIO control, an output-enable register and an output-data register. Each port also has a read-only register that returns the synchronized pin levels. Software reaches them over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data.

Each writable register also appears at a second, masked address. A write there carries a per-bit update mask in bits [15:8] and new values in bits [7:0]. Single pins can then be changed in one bus write, with no read-modify-write, so two agents that touch different pins of the same port cannot undo each other's work. The pin side gives each pin a data value and a drive enable for an external pad, and takes in a raw pin level that passes through a two-flop synchronizer.

Top module: `gpb_bank`

## Requirements
- R1: While rst is high, and on the cycle after, every ownership, output-enable and output-data register is 0. Every register then reads 0 and pin_oe is all zero.
- R2: Address bits [3:2] select the port (pin bits 8p+7..8p). Bits [7:4] select the register: 0x0 ownership, 0x1 output enable, 0x2 output data, 0x3 input. Bits [1:0] are ignored.
- R3: A write to a direct address (group 0x0, 0x1 or 0x2) replaces all 8 bits of that register with bus_wdata[7:0] at the next clock edge. No other register of any port changes.
- R4: A write to group 0x8 (ownership), 0x9 (output enable) or 0xA (output data) changes only the bits whose bit in bus_wdata[15:8] is 1. Each such bit takes the value of the matching bit in bus_wdata[7:0].
- R5: A read of a masked address returns the underlying register. On every read, bits [31:8] are 0.
- R6: pin_oe[i] is 1 exactly when pin i's ownership bit and output-enable bit are both 1. pin_out[i] always follows the output-data bit.
- R7: A pin level applied before clock edge k is not visible in the input register after edge k. It is visible after edge k+1.
- R8: Writes to the input group (0x3) or to any unmapped group change no register. Reads of unmapped groups return 0.
- R9: bus_rdata depends combinationally on bus_addr and the current register state, with no added read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data; [15:8] mask and [7:0] values for masked writes |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Per-pin output data |
| pin_oe | output | 32 | Per-pin drive enable, low means tri-stated |

## Verification
The embedded assertions check, on every cycle, that a port not addressed by a write keeps its registers, that a masked write leaves unmasked bits alone, and that a direct write lands its byte exactly. They also check that writes to the input group or to unmapped groups change nothing, and that reset clears the state. Only the bench scenarios can show that the address decode reaches the intended port and register, that masked aliases read back the underlying value, how ownership and output enable combine on the pins, and the two-edge latency of the input path.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int NUM_PORTS  = 4;
    localparam int PORT_W     = 8;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int PIN_W      = NUM_PORTS * PORT_W;
    localparam int PORT_SEL_W = $clog2(NUM_PORTS);
    localparam int GRP_LSB    = 2 + PORT_SEL_W;
    localparam int GRP_W      = ADDR_W - GRP_LSB;

    typedef enum logic [2:0] {
        K_OWN,
        K_OE,
        K_DATA,
        K_IN,
        K_M_OWN,
        K_M_OE,
        K_M_DATA,
        K_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e               kind;
        logic [PORT_SEL_W-1:0]   port;
    } reg_sel_t;

    function automatic reg_kind_e group_to_kind(input logic [GRP_W-1:0] grp);
        case (grp)
            4'h0:    return K_OWN;
            4'h1:    return K_OE;
            4'h2:    return K_DATA;
            4'h3:    return K_IN;
            4'h8:    return K_M_OWN;
            4'h9:    return K_M_OE;
            4'hA:    return K_M_DATA;
            default: return K_NONE;
        endcase
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = group_to_kind(a[ADDR_W-1:GRP_LSB]);
        s.port = a[GRP_LSB-1:2];
        return s;
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpb_port.sv
module gpb_port
    import gpb_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel,
    input  logic           we,
    input  reg_kind_e      kind,
    input  logic [2*W-1:0] wr_data,
    input  logic [W-1:0]   sync_in,
    output logic [W-1:0]   rd_val,
    output logic [W-1:0]   drv_val,
    output logic [W-1:0]   drv_en
);
    logic [W-1:0] own_q, oe_q, data_q;
    logic [W-1:0] new_val, upd_mask;
    logic         wr_hit;

    function automatic logic [W-1:0] merge_bits(
        input logic [W-1:0] cur, input logic [W-1:0] val, input logic [W-1:0] en);
        return (cur & ~en) | (val & en);
    endfunction

    assign wr_hit   = we && sel;
    assign new_val  = wr_data[W-1:0];
    assign upd_mask = wr_data[2*W-1:W];

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= '0;
            oe_q   <= '0;
            data_q <= '0;
        end else if (wr_hit) begin
            case (kind)
                K_OWN:    own_q  <= new_val;
                K_OE:     oe_q   <= new_val;
                K_DATA:   data_q <= new_val;
                K_M_OWN:  own_q  <= merge_bits(own_q, new_val, upd_mask);
                K_M_OE:   oe_q   <= merge_bits(oe_q, new_val, upd_mask);
                K_M_DATA: data_q <= merge_bits(data_q, new_val, upd_mask);
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (kind)
            K_OWN, K_M_OWN:   rd_val = own_q;
            K_OE, K_M_OE:     rd_val = oe_q;
            K_DATA, K_M_DATA: rd_val = data_q;
            K_IN:             rd_val = sync_in;
            default:          rd_val = '0;
        endcase
    end

    assign drv_val = data_q;
    assign drv_en  = own_q & oe_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (own_q == '0 && oe_q == '0 && data_q == '0)); // R1

    AST_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> ($stable(own_q) && $stable(oe_q) && $stable(data_q))); // R3

    AST_DIRECT_EXACT: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && kind == K_DATA) |=> (data_q == $past(wr_data[W-1:0]))); // R3

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && kind == K_M_DATA) |=>
            (((data_q ^ $past(data_q)) & ~$past(wr_data[2*W-1:W])) == '0)); // R4

    AST_MASK_OE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && kind == K_M_OE) |=>
            (((oe_q ^ $past(oe_q)) & ~$past(wr_data[2*W-1:W])) == '0)); // R4

    AST_NO_WRITE_GROUP: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && (kind == K_IN || kind == K_NONE)) |=>
            ($stable(own_q) && $stable(oe_q) && $stable(data_q))); // R8

endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    localparam int SYNC_STAGES = 2;

    reg_sel_t           dec;
    logic [PIN_W-1:0]   pin_sync;
    logic [PORT_W-1:0]  port_rd [NUM_PORTS];
    logic               unused_bits;

    assign dec         = decode_addr(bus_addr);
    assign unused_bits = ^{bus_wdata[BUS_W-1:2*PORT_W], bus_addr[1:0]};

    gpb_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            gpb_port #(.W(PORT_W)) u_port (
                .clk     (clk),
                .rst     (rst),
                .sel     (dec.port == PORT_SEL_W'(p)),
                .we      (bus_we),
                .kind    (dec.kind),
                .wr_data (bus_wdata[2*PORT_W-1:0]),
                .sync_in (pin_sync[p*PORT_W +: PORT_W]),
                .rd_val  (port_rd[p]),
                .drv_val (pin_out[p*PORT_W +: PORT_W]),
                .drv_en  (pin_oe[p*PORT_W +: PORT_W])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        bus_rdata[PORT_W-1:0] = port_rd[dec.port];
    end

    AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:PORT_W] == '0); // R5

endmodule

// File: tb/gpb_bank_test.sv
`timescale 1ns/1ps
module gpb_bank_test;
    import gpb_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_we;
    logic [BUS_W-1:0]  bus_wdata;
    logic [BUS_W-1:0]  bus_rdata;
    logic [PIN_W-1:0]  pin_in;
    logic [PIN_W-1:0]  pin_out;
    logic [PIN_W-1:0]  pin_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpb_bank uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {write addr, write data, read addr, expected read, requirement number}
    localparam int NV = 10;
    localparam logic [87:0] VEC [NV] = '{
        {8'h00, 32'h0000_00FF, 8'h00, 32'h0000_00FF, 8'd3}, // R3 ownership port 0
        {8'h14, 32'h0000_005A, 8'h14, 32'h0000_005A, 8'd3}, // R3 output enable port 1
        {8'h24, 32'h0000_000F, 8'h20, 32'h0000_0000, 8'd3}, // R3 port 0 untouched
        {8'hA4, 32'h0000_F0A5, 8'h24, 32'h0000_00AF, 8'd4}, // R4 masked data
        {8'h94, 32'h0000_0300, 8'h14, 32'h0000_0058, 8'd4}, // R4 masked clear
        {8'h80, 32'h0000_8000, 8'h80, 32'h0000_007F, 8'd5}, // R5 alias read
        {8'h30, 32'h0000_00FF, 8'h30, 32'h0000_0000, 8'd8}, // R8 input write
        {8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000, 8'd8}, // R8 unmapped
        {8'h2F, 32'hFFFF_FF3C, 8'h2C, 32'h0000_003C, 8'd2}, // R2 low addr bits ignored
        {8'hAC, 32'h0000_00FF, 8'hAC, 32'h0000_003C, 8'd4}  // R4 empty mask
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp); // R9: same-cycle read
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int p = 0; p < 4; p++) begin
            read_check("R1", 8'(p*4),        32'h0);
            read_check("R1", 8'(16 + p*4),   32'h0);
            read_check("R1", 8'(32 + p*4),   32'h0);
        end
        check("R1", pin_oe, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][87:80], VEC[i][79:48]);
            read_check($sformatf("R%0d", VEC[i][7:0]), VEC[i][47:40], VEC[i][39:8]);
        end

        // R6 pin drive: port1 owned, port0 output enable set
        bus_write(8'h04, 32'h0000_00FF);
        bus_write(8'h10, 32'h0000_00FF);
        #1;
        check("R6", pin_oe,  32'h0000_587F);
        check("R6", pin_out, 32'h3C00_AF00);

        // R7 two-edge input latency
        @(negedge clk);
        pin_in = 32'hC3A5_1E00;
        @(negedge clk);
        read_check("R7", 8'h34, 32'h0000_0000);
        @(negedge clk);
        read_check("R7", 8'h34, 32'h0000_001E);
        read_check("R7", 8'h3C, 32'h0000_00C3);
        read_check("R7", 8'h38, 32'h0000_00A5);

        // R1 reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_check("R1", 8'h24, 32'h0);
        read_check("R1", 8'h00, 32'h0);
        check("R1", pin_oe, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule